// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Return Stack

This block decides when a small sequencer is diverted into an interrupt routine and where it goes. It watches two external request pins and one timer request line. Each pin has a rising-edge detector and its own mask flip-flop. The first rising edge after the mask is cleared raises an input request and arms the mask, so that later edges on that pin are ignored until the mask is cleared again. Input and timer requests are held in two separate latches. A global enable flip-flop gates whether either latch may be served.

While the enable is set and a latch is pending, the block presents a valid vector. The input vector is word 1 of the top page and the timer vector is word 0 of that page. The input request is served first. On the next clock edge the block pushes the sequencer's current program counter onto a four-level return stack, clears the latch it served and clears the enable.

A plain return strobe pops the stack. A return-from-interrupt strobe pops the stack and sets the enable. A separate strobe lets the program set the enable directly, which allows nested interrupts. The mask bits and the raw pin levels can be read back, so the pins can also be used as latched inputs.

Top module: `irq_arbiter_stack`

## Requirements
- R1: A rising edge on a pin whose mask bit is 0 sets that mask bit and sets the input request latch. `mask_o` shows the mask bits, and `pin_o` shows the raw pin levels in the same cycle.
- R2: A rising edge on a pin whose mask bit is already 1 raises no request, and the mask bit stays 1.
- R3: A pulse on `mask_clr_i[i]` clears mask bit i on the next edge. If a rising edge on pin i arrives in the same cycle, the mask bit stays 1.
- R4: After reset the global enable is 0, the stack is all zeros and the masks are 0. While the enable is 0, pending requests stay latched and `vec_valid_o` stays 0.
- R5: `vec_valid_o` is 1 exactly when the enable is 1 and a latch is pending. On the edge that ends a valid cycle, the enable and the served latch clear, so `vec_valid_o` is 0 in the next cycle.
- R6: When both latches are pending, the input request is served first with `vec_addr_o` = 0xFC1 (page 0x3F, word 1). The timer latch stays set and is served afterwards with `vec_addr_o` = 0xFC0 (page 0x3F, word 0).
- R7: On entry, `pc_i` is pushed to level 1, levels 1 to 3 move to levels 2 to 4, and the old level 4 is lost. `pc_ret_o` shows level 1.
- R8: `ret_i` pops the stack: level 2 moves to level 1, levels 3 and 4 move up one, and level 4 keeps its value.
- R9: `rti_i` pops the stack as `ret_i` does and sets the enable. `ie_set_i` sets the enable without touching the stack.
- R10: If an entry and a return strobe fall in the same cycle, the entry wins. The return is ignored: there is no pop and the enable stays 0.
- R11: A new request that sets a latch in the same cycle that the latch is served remains pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPIN | External request pins, synchronous levels |
| mask_clr_i | input | NPIN | Per-pin mask clear strobes |
| tmr_req_i | input | 1 | Timer request pulse |
| ie_set_i | input | 1 | Set the global enable |
| ret_i | input | 1 | Plain return: pop the stack |
| rti_i | input | 1 | Return from interrupt: pop the stack and set the enable |
| pc_i | input | PC_W | Current program counter, pushed on entry |
| vec_valid_o | output | 1 | Interrupt entry this cycle |
| vec_addr_o | output | PC_W | Vector address {page, word} |
| pc_ret_o | output | PC_W | Stack level 1 (return address) |
| mask_o | output | NPIN | Mask flip-flop readback |
| pin_o | output | NPIN | Raw pin level readback |

## Verification
Three pairs of functions can land in the same clock cycle. First, an entry and a return can collide. The bench sets the enable with a timer request pending and then raises `rti_i` in the cycle the vector is valid. It judges the result by seeing that `pc_ret_o` holds the newly pushed value rather than a popped one, and that a later request is not served. Second, a new pin edge can arrive while the input latch is being served. The bench checks that the request is presented again once the enable is restored. Third, a mask clear can meet an edge on the same pin. The bench checks that the mask bit stays set.

// File: rtl/irq_arbiter_stack.sv
module irq_arbiter_stack #(
  parameter int PAGE_W = 6,
  parameter int WORD_W = 6,
  parameter int NPIN   = 2,
  parameter int DEPTH  = 4,
  localparam int PC_W  = PAGE_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [NPIN-1:0]   mask_clr_i,
  input  logic              tmr_req_i,
  input  logic              ie_set_i,
  input  logic              ret_i,
  input  logic              rti_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              vec_valid_o,
  output logic [PC_W-1:0]   vec_addr_o,
  output logic [PC_W-1:0]   pc_ret_o,
  output logic [NPIN-1:0]   mask_o,
  output logic [NPIN-1:0]   pin_o
);
  localparam logic [PAGE_W-1:0] VPAGE  = {PAGE_W{1'b1}};
  localparam logic [PC_W-1:0]   VEC_IN = {VPAGE, WORD_W'(1)};
  localparam logic [PC_W-1:0]   VEC_TM = {VPAGE, {WORD_W{1'b0}}};

  logic [NPIN-1:0] pin_q, mask, lead, fire;
  logic            in_req, tm_req, ie;
  logic            take_in, take_tm, pop;
  logic [PC_W-1:0] stk [DEPTH];

  assign lead    = pin_i & ~pin_q;
  assign fire    = lead & ~mask;
  assign vec_valid_o = ie & (in_req | tm_req);
  assign take_in = vec_valid_o & in_req;
  assign take_tm = vec_valid_o & ~in_req;
  assign pop     = (ret_i | rti_i) & ~vec_valid_o;
  assign vec_addr_o = in_req ? VEC_IN : VEC_TM;
  assign pc_ret_o = stk[0];
  assign mask_o  = mask;
  assign pin_o   = pin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      mask   <= '0;
      in_req <= 1'b0;
      tm_req <= 1'b0;
      ie     <= 1'b0;
    end else begin
      pin_q  <= pin_i;
      mask   <= (mask & ~mask_clr_i) | lead;
      in_req <= (in_req & ~take_in) | (|fire);
      tm_req <= (tm_req & ~take_tm) | tmr_req_i;
      if (vec_valid_o)             ie <= 1'b0;
      else if (rti_i || ie_set_i)  ie <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [PC_W-1:0] push_val, pop_val;
    if (i == 0) begin : g_top
      assign push_val = pc_i;
    end else begin : g_mid
      assign push_val = stk[i-1];
    end
    if (i == DEPTH-1) begin : g_bot
      assign pop_val = stk[i];
    end else begin : g_up
      assign pop_val = stk[i+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stk[i] <= '0;
      else if (vec_valid_o) stk[i] <= push_val;
      else if (pop)         stk[i] <= pop_val;
    end
  end
endmodule

module irq_arbiter_stack_chk #(
  parameter int PC_W = 12,
  parameter int NPIN = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] pin,
  input logic [NPIN-1:0] pin_q,
  input logic [NPIN-1:0] mask_clr,
  input logic [NPIN-1:0] mask,
  input logic            vec_valid,
  input logic [PC_W-1:0] vec_addr,
  input logic [PC_W-1:0] pc_in,
  input logic [PC_W-1:0] pc_ret,
  input logic [PC_W-1:0] lvl2,
  input logic            in_req,
  input logic            tm_req,
  input logic            ie,
  input logic            ret,
  input logic            rti
);
  localparam logic [PC_W-1:0] VEC_IN = {{(PC_W-6){1'b1}}, 6'd1};

  assert_exit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  assert_push_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> pc_ret == $past(pc_in));

  assert_timer_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_addr == VEC_IN && tm_req) |=> tm_req);

  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask && !in_req) |=> !in_req);

  assert_pop_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !vec_valid) |=> pc_ret == $past(lvl2));

  assert_rti_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !vec_valid) |=> ie);

  assert_entry_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && (ret || rti)) |=> !ie);

  assert_clr_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_clr[0] && !(pin[0] && !pin_q[0])) |=> !mask[0]);

  assert_held_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !vec_valid);
endmodule

bind irq_arbiter_stack irq_arbiter_stack_chk #(.PC_W(PC_W), .NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin(pin_i), .pin_q(pin_q), .mask_clr(mask_clr_i),
  .mask(mask), .vec_valid(vec_valid_o), .vec_addr(vec_addr_o), .pc_in(pc_i),
  .pc_ret(pc_ret_o), .lvl2(stk[1]), .in_req(in_req), .tm_req(tm_req), .ie(ie),
  .ret(ret_i), .rti(rti_i)
);

// File: tb/tb_irq_arbiter_stack.sv
`timescale 1ns/1ps
module tb_irq_arbiter_stack;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pin_i, mask_clr_i, mask_o, pin_o;
  logic        tmr_req_i, ie_set_i, ret_i, rti_i, vec_valid_o;
  logic [11:0] pc_i, vec_addr_o, pc_ret_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_arbiter_stack dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mask_clr_i(mask_clr_i),
    .tmr_req_i(tmr_req_i), .ie_set_i(ie_set_i), .ret_i(ret_i), .rti_i(rti_i),
    .pc_i(pc_i), .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o),
    .pc_ret_o(pc_ret_o), .mask_o(mask_o), .pin_o(pin_o)
  );

  typedef struct packed {
    logic [1:0]  pins, clr;
    logic        tmr, ies, rti, ret;
    logic [11:0] pc;
    logic        vv;
    logic [11:0] va, pco;
    logic [1:0]  msk;
  } row_t;

  localparam int NROW = 14;
  localparam row_t TBL [NROW] = '{
    '{2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0, 12'hFC0, 12'h000, 2'b00},
    '{2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 1'b1, 12'hFC1, 12'h000, 2'b01},
    '{2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h123, 1'b0, 12'hFC0, 12'h123, 2'b01},
    '{2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'hFC0, 12'h123, 2'b01},
    '{2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'hFC0, 12'h123, 2'b01},
    '{2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 1'b1, 12'hFC0, 12'h000, 2'b01},
    '{2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h055, 1'b0, 12'hFC0, 12'h055, 2'b01},
    '{2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'hFC0, 12'h055, 2'b00},
    '{2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'hFC0, 12'h055, 2'b00},
    '{2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'hFC1, 12'h055, 2'b10},
    '{2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 1'b1, 12'hFC1, 12'h000, 2'b10},
    '{2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h200, 1'b0, 12'hFC0, 12'h200, 2'b10},
    '{2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 1'b1, 12'hFC0, 12'h000, 2'b10},
    '{2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'h300, 1'b0, 12'hFC0, 12'h300, 2'b10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic [1:0] c, input logic t,
                       input logic s, input logic ri, input logic r, input logic [11:0] pc);
    pin_i = p; mask_clr_i = c; tmr_req_i = t; ie_set_i = s;
    rti_i = ri; ret_i = r; pc_i = pc;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pin_i = '0; mask_clr_i = '0; tmr_req_i = 0; ie_set_i = 0; rti_i = 0; ret_i = 0; pc_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R4 reset vec_valid", vec_valid_o, 0);
    chk("R4 reset stack", pc_ret_o, 0);
    chk("R4 reset mask", mask_o, 0);

    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i].pins, TBL[i].clr, TBL[i].tmr, TBL[i].ies, TBL[i].rti, TBL[i].ret, TBL[i].pc);
      chk($sformatf("R5/R6 row %0d vec_valid", i), vec_valid_o, TBL[i].vv);
      chk($sformatf("R6 row %0d vec_addr", i), vec_addr_o, TBL[i].va);
      chk($sformatf("R7/R8/R9 row %0d pc_ret", i), pc_ret_o, TBL[i].pco);
      chk($sformatf("R1/R2/R3 row %0d mask", i), mask_o, TBL[i].msk);
      chk($sformatf("R1 row %0d pin readback", i), pin_o, TBL[i].pins);
    end

    // R3: clear and edge in the same cycle, set wins
    drive(2'b10, 2'b10, 0, 0, 0, 0, 12'h000);
    chk("R3 set beats clear", mask_o, 2'b10);
    chk("R2 masked edge no request", vec_valid_o, 0);
    drive(2'b10, 2'b10, 0, 0, 0, 0, 12'h000);
    chk("R3 clear", mask_o, 2'b00);

    // R11: new edge while the input latch is served
    do_reset();
    drive(2'b01, 2'b00, 0, 1, 0, 0, 12'h000);
    chk("R1 first edge valid", vec_valid_o, 1);
    drive(2'b11, 2'b00, 0, 0, 0, 0, 12'h0A0);
    chk("R5 taken", vec_valid_o, 0);
    chk("R7 pushed", pc_ret_o, 12'h0A0);
    drive(2'b11, 2'b00, 0, 1, 0, 0, 12'h000);
    chk("R11 request kept", vec_valid_o, 1);
    chk("R11 input vector", vec_addr_o, 12'hFC1);
    drive(2'b00, 2'b00, 0, 0, 0, 0, 12'h0B0);

    // R7/R8: overflow drops the deepest level, pop keeps level 4
    for (int k = 1; k <= 4; k++) begin
      drive(2'b00, 2'b00, 1, 1, 0, 0, 12'h000);
      drive(2'b00, 2'b00, 0, 0, 0, 0, 12'h100 + 12'(k));
    end
    chk("R7 top after pushes", pc_ret_o, 12'h104);
    drive(2'b00, 2'b00, 0, 0, 0, 1, 12'h000);
    chk("R8 pop 1", pc_ret_o, 12'h103);
    drive(2'b00, 2'b00, 0, 0, 0, 1, 12'h000);
    chk("R8 pop 2", pc_ret_o, 12'h102);
    drive(2'b00, 2'b00, 0, 0, 0, 1, 12'h000);
    chk("R7 oldest dropped", pc_ret_o, 12'h101);
    drive(2'b00, 2'b00, 0, 0, 0, 1, 12'h000);
    chk("R8 level 4 kept", pc_ret_o, 12'h101);

    // R10: entry and return in the same cycle
    drive(2'b00, 2'b00, 1, 1, 0, 0, 12'h000);
    chk("R9 ie_set enables", vec_valid_o, 1);
    drive(2'b00, 2'b00, 0, 0, 1, 0, 12'h0CC);
    chk("R10 entry wins over return", pc_ret_o, 12'h0CC);
    drive(2'b00, 2'b00, 1, 0, 0, 0, 12'h000);
    chk("R10 enable stays clear", vec_valid_o, 0);
    drive(2'b00, 2'b00, 0, 0, 1, 0, 12'h000);
    chk("R9 rti pops", pc_ret_o, 12'h101);
    chk("R9 rti enables timer", vec_valid_o, 1);
    chk("R6 timer vector", vec_addr_o, 12'hFC0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule